// File: doc/BRIEF.md
# Single-to-Double Floating-Point Widening Converter

This block turns a 32-bit single-precision floating-point word into the 64-bit double-precision register image that a load-single operation places in a floating-point register. It is a pure format change. Nothing is rounded and no flag is raised, because every single-precision value can be represented exactly as a double.

There are three classes of input, and each has its own path. An operand with a biased exponent from 1 to 254 gets a direct bit remap: the three extra exponent bits are filled with the inverse of the top exponent bit. A true zero, an infinity or a NaN gets the same remap, except that those three bits copy the top exponent bit. A denormal operand is normalised, so that it becomes an ordinary normal double. A leading-zero count over the fraction finds the shift in one step, and the exponent is rebiased from that count.

The result is registered, so there is exactly one cycle of latency. The reset input is asynchronous and active low. Its release passes through a two-stage synchroniser inside the block.

Top module: `fp_single_widen`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low after each cycle in which `in_valid` is low. Back-to-back inputs give back-to-back outputs.
- R2: While `rst_n` is low, `out_valid` is low. Asserting `rst_n` clears `out_valid` at once, without waiting for a clock edge.
- R3: A normal input has a biased exponent field `in_word[30:23]` from 1 to 254. For it, `out_word[63:62]` = `in_word[31:30]`, each of `out_word[61:59]` = `~in_word[30]`, `out_word[58:29]` = `in_word[29:0]`, and `out_word[28:0]` = 0.
- R4: A zero input has `in_word[30:0]` = 0. It gives `out_word` = {`in_word[31]`, 63 zero bits}, so the sign of the zero is kept.
- R5: An input with exponent field 255 (infinity or NaN, quiet or signalling) gives `out_word[63:62]` = `in_word[31:30]`, each of `out_word[61:59]` = `in_word[30]`, `out_word[58:29]` = `in_word[29:0]` and `out_word[28:0]` = 0. The payload is kept bit for bit.
- R6: A denormal input has exponent field 0 and a nonzero fraction `in_word[22:0]`. Let z be the number of leading zeros of its 23-bit fraction. The output exponent field `out_word[62:52]` is then 896 − z, a value from 874 to 896.
- R7: For a denormal input, `out_word[51:29]` is the fraction shifted left by z+1 places, with the bits shifted out at the top dropped. `out_word[28:0]` is 0.
- R8: `out_word[63]` equals `in_word[31]` for every input class.
- R9: While `in_valid` is low, `out_word` keeps its last value whatever `in_word` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 32 | Single-precision operand |
| out_valid | output | 1 | Qualifies `out_word`; follows `in_valid` by one cycle |
| out_word | output | 64 | Double-precision image of the operand |

## Verification
Every result is due one cycle after its input: on the first rising edge after `in_valid` is seen. The bench drives inputs on falling edges and reads the output on the next falling edge, half a period after the edge that captured it. In the back-to-back denormal sweep, the output for operand k is read in the same falling edge at which operand k+1 is driven. The hold check for R9 and the reset checks read the ports several cycles after the stimulus. The asynchronous clear is read one time unit after `rst_n` falls, with no clock edge in between.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  // single-precision layout
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;
  // double-precision layout
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int DP_BIAS   = 1023;
  // derived
  localparam int SP_EMIN     = 1 - SP_BIAS;
  localparam int EXP_PAD     = DP_EXP_W - SP_EXP_W;
  localparam int FRAC_PAD    = DP_FRAC_W - SP_FRAC_W;
  localparam int DEN_EXP_TOP = DP_BIAS + SP_EMIN - 1;
  localparam int LZ_W        = $clog2(SP_FRAC_W + 1);

  typedef enum logic [1:0] {
    CLS_NORMAL  = 2'd0,
    CLS_DENORM  = 2'd1,
    CLS_SPECIAL = 2'd2
  } fpw_class_e;
endpackage

// File: rtl/fpw_rst_sync.sv
module fpw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpw_classify.sv
module fpw_classify
  import fpw_pkg::*;
(
  input  logic [SP_EXP_W-1:0]  exp_i,
  input  logic [SP_FRAC_W-1:0] frac_i,
  output fpw_class_e           cls_o
);
  logic exp_zero, exp_ones, frac_zero;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_ones  = &exp_i;
    frac_zero = (frac_i == '0);
    if (exp_ones || (exp_zero && frac_zero)) cls_o = CLS_SPECIAL;
    else if (exp_zero)                        cls_o = CLS_DENORM;
    else                                      cls_o = CLS_NORMAL;
  end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter  int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_assemble.sv
module fpw_assemble
  import fpw_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  input  fpw_class_e      cls_i,
  input  logic [LZ_W-1:0] lz_i,
  output logic [DP_W-1:0] word_o
);
  logic                 sign;
  logic [SP_FRAC_W-1:0] frac;
  logic [LZ_W-1:0]      shamt;
  logic [SP_FRAC_W-1:0] frac_norm;
  logic [DP_EXP_W-1:0]  den_exp;
  logic                 pad_bit;

  always_comb begin
    sign      = word_i[SP_W-1];
    frac      = word_i[SP_FRAC_W-1:0];
    shamt     = lz_i + LZ_W'(1);
    frac_norm = frac << shamt;
    den_exp   = DP_EXP_W'(DEN_EXP_TOP) - DP_EXP_W'(lz_i);
    pad_bit   = (cls_i == CLS_NORMAL) ? ~word_i[SP_W-2] : word_i[SP_W-2];
    if (cls_i == CLS_DENORM)
      word_o = {sign, den_exp, frac_norm, {FRAC_PAD{1'b0}}};
    else
      word_o = {word_i[SP_W-1:SP_W-2], {EXP_PAD{pad_bit}},
                word_i[SP_W-3:0], {FRAC_PAD{1'b0}}};
  end
endmodule

// File: rtl/fp_single_widen.sv
module fp_single_widen
  import fpw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_word,
  output logic            out_valid,
  output logic [DP_W-1:0] out_word
);
  logic            rst_int_n;
  fpw_class_e      cls;
  logic [LZ_W-1:0] lz;
  logic [DP_W-1:0] word_nxt;
  logic            vld_d, vld_q;
  logic [DP_W-1:0] word_q;

  fpw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_int_n)
  );

  fpw_classify u_cls (
    .exp_i (in_word[SP_W-2:SP_FRAC_W]),
    .frac_i(in_word[SP_FRAC_W-1:0]),
    .cls_o (cls)
  );

  fpw_lzc #(.W(SP_FRAC_W)) u_lzc (
    .vec_i(in_word[SP_FRAC_W-1:0]),
    .cnt_o(lz)
  );

  fpw_assemble u_asm (
    .word_i(in_word),
    .cls_i (cls),
    .lz_i  (lz),
    .word_o(word_nxt)
  );

  always_comb vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  // data path: no reset, explicit clock enable
  always_ff @(posedge clk) begin
    if (in_valid) word_q <= word_nxt;
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker
  import fpw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [SP_W-1:0] in_word,
  input logic            out_valid,
  input logic [DP_W-1:0] out_word
);
  logic loaded_q;
  logic in_normal, in_special, in_denorm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        loaded_q <= 1'b0;
    else if (in_valid) loaded_q <= 1'b1;
  end

  always_comb begin
    in_special = (in_word[30:23] == 8'hFF) || (in_word[30:0] == '0);
    in_denorm  = (in_word[30:23] == 8'h00) && (in_word[22:0] != '0);
    in_normal  = !in_special && !in_denorm;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_NORMAL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_normal |=> out_word[61:59] == {3{~$past(in_word[30])}}); // R3
  AST_SPECIAL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_special |=> out_word[61:59] == {3{$past(in_word[30])}}); // R5
  AST_DENORM_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_denorm |=> (out_word[62:52] >= 11'd874) && (out_word[62:52] <= 11'd896)); // R6
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[28:0] == '0); // R7
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[63] == $past(in_word[31])); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q && !in_valid |=> $stable(out_word)); // R9
endmodule

bind fp_single_widen fpw_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_word  (in_word),
  .out_valid(out_valid),
  .out_word (out_word)
);

// File: tb/tb_fp_single_widen.sv
module tb_fp_single_widen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [63:0] out_word;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 250 MHz

  fp_single_widen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  localparam int NV = 14;
  localparam logic [31:0] VIN [NV] = '{
    32'h3F800000, 32'hC0000000, 32'h40A00000, 32'h7F7FFFFF, 32'h00800000, // R3
    32'h00000000, 32'h80000000,                                           // R4
    32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h7F800001,               // R5
    32'h00000001, 32'h00400000, 32'h80000001                              // R6 R7
  };
  localparam logic [63:0] VEXP [NV] = '{
    64'h3FF0000000000000, 64'hC000000000000000, 64'h4014000000000000,
    64'h47EFFFFFE0000000, 64'h3810000000000000,
    64'h0000000000000000, 64'h8000000000000000,
    64'h7FF0000000000000, 64'hFFF0000000000000, 64'h7FF8000000000000,
    64'h7FF0000020000000,
    64'h36A0000000000000, 64'h3800000000000000, 64'hB6A0000000000000
  };
  localparam int VREQ [NV] = '{3, 3, 3, 3, 3, 4, 4, 5, 5, 5, 5, 6, 6, 8};

  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    logic        s;
    int          e;
    int          ex;
    logic [22:0] f;
    logic [23:0] m;
    s = w[31];
    e = int'(w[30:23]);
    f = w[22:0];
    if (e == 255) return {s, 11'h7FF, f, 29'b0};
    if (e == 0 && f == 0) return {s, 63'b0};
    if (e == 0) begin
      m  = {1'b0, f};
      ex = -126;
      while (!m[23]) begin
        m  = m << 1;
        ex = ex - 1;
      end
      return {s, 11'(ex + 1023), m[22:0], 29'b0};
    end
    return {s, 11'(e + 1023 - 127), f, 29'b0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge, after capture
  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] prev;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    chk("R2 valid low in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", 64'(out_valid), 64'd0);

    // table of hand-computed vectors
    for (int i = 0; i < NV; i++) begin
      send(VIN[i]);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), out_word, VEXP[i]);
      chk("R1 valid after input", 64'(out_valid), 64'd1);
    end
    @(negedge clk);
    chk("R1 valid drops", 64'(out_valid), 64'd0);

    // R6 R7: every denormal shift position, streamed back to back
    prev     = 32'h00000001;
    in_valid = 1'b1;
    in_word  = prev;
    for (int k = 1; k <= 23; k++) begin
      @(negedge clk);
      chk("R6/R7 denormal sweep", out_word, ref_widen(prev));
      chk("R1 back-to-back valid", 64'(out_valid), 64'd1);
      if (k < 23) begin
        prev    = (32'h00000001 << k) | (k[0] ? 32'h80000000 : 32'h0) | ((32'h1 << k) - 1) & 32'h00000155;
        in_word = prev;
      end else begin
        in_valid = 1'b0;
      end
    end

    // R3 R8: every normal exponent with a varying fraction and sign
    for (int e = 1; e < 255; e++) begin
      w = {e[0], 8'(e), 23'(e * 32'h13579)};
      send(w);
      chk("R3 normal sweep", out_word, ref_widen(w));
      chk("R8 sign", 64'(out_word[63]), 64'(w[31]));
    end

    // R5: NaN payloads
    for (int p = 0; p < 8; p++) begin
      w = {p[0], 8'hFF, 23'(32'h00400000 >> p) | 23'(p)};
      send(w);
      chk("R5 NaN payload", out_word, ref_widen(w));
    end

    // R9: idle input changes do not reach the output
    send(32'h40A00000);
    in_word = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    chk("R9 hold while idle", out_word, 64'h4014000000000000);
    chk("R1 no valid while idle", 64'(out_valid), 64'd0);

    // R2: asynchronous clear in the middle of a run
    send(32'h3F800000);
    chk("R1 valid before reset", 64'(out_valid), 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R2 async clear", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(32'hC0000000);
    chk("R1 recovery after reset", 64'(out_valid), 64'd1);
    chk("R3 recovery data", out_word, 64'hC000000000000000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule